// File: doc/BRIEF.md
# Register-Driven Short-Transfer I2C Master

This block is an I2C bus master that a host drives through six byte-wide registers. One transaction carries between one and four data bytes to or from a single slave. The host loads the payload bytes and the slave address byte, then writes one control byte. That byte holds the direction and the byte count, and writing it starts the transfer. The engine sends a START condition and the address byte, then moves the data bytes. It checks the acknowledge bit after every byte it transmits, and it closes every transfer with a STOP condition.

The host polls the status register. While the transfer runs, status holds a busy value. When the transfer ends, status holds either the control code that was issued, or a separate code if the slave left an acknowledge slot high. Payload bytes sit in descending register order: data register 3 holds the first byte on the wire, register 2 the second, and so on. Received bytes are written back in that same order. The SCL rate comes from a clock divider parameter. Each bit slot lasts four quarter-periods of `QUARTER_CLKS` clocks.

Top module: `short_i2c_master`

## Requirements
- R1: After reset, status (register 5) reads 0x00, SCL is high and SDA is released.
- R2: Writing control value 0x80+N-1 (N = 1..4) to register 5 starts a write. The engine sends START, then the address byte: bits 7:1 of register 4 with 0 in bit 0. It then sends N data bytes, MSB first, taken from register 3 downward to register 4-N.
- R3: Writing control value 0x84+N-1 starts a read. The engine sends the address byte with 1 in bit 0 and receives N bytes. The first byte lands in register 3, the next in register 2, and so on. Data registers below 4-N keep their values.
- R4: From the accepted control write until completion, status reads 0x40 plus the low three bits of the control code.
- R5: A write in which every byte is acknowledged ends with status equal to the issued control code (0x80..0x83).
- R6: A read whose address is acknowledged ends with status equal to the issued control code (0x84..0x87).
- R7: If the slave leaves SDA high in the acknowledge slot of the address byte or of any written byte, the remaining bytes are skipped, a STOP is sent, and status becomes 0x94+N-1.
- R8: During a read, the master pulls SDA low in the acknowledge slot of every received byte except the last. It leaves SDA high after the last byte.
- R9: Every accepted transfer contains exactly one START and ends with exactly one STOP. Inside a bit slot, SDA changes only while SCL is low.
- R10: While a transfer is in progress, host writes to any register are ignored. This includes a second control write, which does not change the status or start another transfer.
- R11: A control value outside 0x80..0x87 is ignored: no bus activity starts and the status keeps its value.
- R12: Once the engine is idle, SCL stays high and SDA stays released until the next accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_sel | input | 3 | Register number for the write (0-3 data, 4 address, 5 control) |
| host_wr_data | input | 8 | Write data |
| host_rd_sel | input | 3 | Register number for the read; 6 and 7 read as zero |
| host_rd_data | output | 8 | Registered read data, one cycle after host_rd_sel |
| scl_out | output | 1 | SCL level (1 = released high) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest situations to reach from the ports are a refused acknowledge part-way through a write, and a host write that lands while the engine is busy. The bench surrounds the block with a behavioural slave model. The model can refuse any chosen byte of a transfer, and it records the master's acknowledge bits on reads, so the bench can check the early STOP and the 0x94-based status code. In the middle of a read, the bench writes a data register, the address register and a new control value, and then reads all of them back once the transfer has finished.

// File: rtl/short_i2c_pkg.sv
package short_i2c_pkg;
  localparam int MAX_BYTES = 4;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  localparam logic [2:0] SEL_SLAVE = 3'd4;
  localparam logic [2:0] SEL_CTRL  = 3'd5;

  localparam logic [7:0] BUSY_BASE = 8'h40;
  localparam logic [7:0] NACK_BASE = 8'h94;

  typedef logic [MAX_BYTES-1:0][7:0] data_vec_t;

  typedef enum logic [1:0] {
    PHY_START = 2'd0,
    PHY_STOP  = 2'd1,
    PHY_BIT   = 2'd2
  } phy_cmd_e;
endpackage

// File: rtl/short_i2c_phy.sv
module short_i2c_phy
  import short_i2c_pkg::*;
#(
  parameter int unsigned QUARTER_CLKS = 63
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  phy_cmd_e cmd,
  input  logic     tx_bit,
  input  logic     sda_in,
  output logic     cmd_done,
  output logic     rx_bit,
  output logic     scl_out,
  output logic     sda_oe
);
  localparam int unsigned CNT_W = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER_CLKS - 1);

  logic             busy_q;
  phy_cmd_e         cmd_q;
  logic             tx_q;
  logic [1:0]       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             scl_q, sda_oe_q, done_q, rx_q;
  logic             tick;

  assign tick = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cmd_q    <= PHY_BIT;
      tx_q     <= 1'b1;
      phase_q  <= '0;
      cnt_q    <= '0;
      scl_q    <= 1'b1;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q  <= 1'b1;
          cmd_q   <= cmd;
          tx_q    <= tx_bit;
          phase_q <= '0;
          cnt_q   <= '0;
        end
      end else if (tick) begin
        cnt_q   <= '0;
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        unique case (cmd_q)
          PHY_START: begin
            case (phase_q)
              2'd0: begin scl_q <= 1'b1; sda_oe_q <= 1'b0; end
              2'd1: sda_oe_q <= 1'b1;
              2'd3: scl_q <= 1'b0;
              default: ;
            endcase
          end
          PHY_STOP: begin
            case (phase_q)
              2'd0: begin scl_q <= 1'b0; sda_oe_q <= 1'b1; end
              2'd1: scl_q <= 1'b1;
              2'd3: sda_oe_q <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (phase_q)
              2'd0: begin scl_q <= 1'b0; sda_oe_q <= !tx_q; end
              2'd1: scl_q <= 1'b1;
              2'd2: rx_q <= sda_in;
              default: scl_q <= 1'b0;
            endcase
          end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cmd_done = done_q;
  assign rx_bit   = rx_q;
  assign scl_out  = scl_q;
  assign sda_oe   = sda_oe_q;

  // R9: data may only move while the clock line is low inside a bit slot
  assert_sda_in_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_q == PHY_BIT && scl_q && $past(scl_q)) |-> $stable(sda_oe_q));

  // R9: the byte sequencer never issues a new bus step over a running one
  assert_phy_free_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !busy_q);
endmodule

// File: rtl/short_i2c_seq.sv
module short_i2c_seq
  import short_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             go_read,
  input  logic [IDX_W-1:0] go_last,
  input  logic [7:0]       slave_byte,
  input  data_vec_t        data_vec,
  input  logic             phy_done,
  input  logic             phy_rx,
  output logic             phy_valid,
  output phy_cmd_e         phy_cmd,
  output logic             phy_tx,
  output logic             busy,
  output logic             done,
  output logic             done_nack,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_byte
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_SHIFT, SQ_ACK, SQ_STOP} sq_state_e;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_BYTES - 1);

  sq_state_e        state_q;
  logic             issued_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic             is_addr_q, rd_q, nack_q;
  logic [IDX_W-1:0] last_q, dcnt_q;
  logic             rx_phase;
  logic [IDX_W-1:0] nxt_cnt;
  logic [7:0]       nxt_byte;

  assign rx_phase = rd_q && !is_addr_q;
  assign nxt_cnt  = is_addr_q ? '0 : dcnt_q + 1'b1;
  assign nxt_byte = data_vec[TOP_IDX - nxt_cnt];

  assign busy      = (state_q != SQ_IDLE);
  assign phy_valid = busy && !issued_q;

  always_comb begin
    phy_cmd = PHY_BIT;
    phy_tx  = 1'b1;
    case (state_q)
      SQ_START: phy_cmd = PHY_START;
      SQ_STOP:  phy_cmd = PHY_STOP;
      SQ_SHIFT: phy_tx  = rx_phase ? 1'b1 : sh_q[7];
      SQ_ACK:   phy_tx  = rx_phase ? (dcnt_q == last_q) : 1'b1;
      default: ;
    endcase
  end

  assign done      = (state_q == SQ_STOP) && phy_done;
  assign done_nack = nack_q;
  assign rx_we     = (state_q == SQ_ACK) && phy_done && rx_phase;
  assign rx_idx    = TOP_IDX - dcnt_q;
  assign rx_byte   = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      issued_q  <= 1'b0;
      sh_q      <= '0;
      bit_q     <= '0;
      is_addr_q <= 1'b0;
      rd_q      <= 1'b0;
      nack_q    <= 1'b0;
      last_q    <= '0;
      dcnt_q    <= '0;
    end else begin
      if (phy_done)       issued_q <= 1'b0;
      else if (phy_valid) issued_q <= 1'b1;

      case (state_q)
        SQ_IDLE: if (go) begin
          state_q <= SQ_START;
          rd_q    <= go_read;
          last_q  <= go_last;
          dcnt_q  <= '0;
          nack_q  <= 1'b0;
        end
        SQ_START: if (phy_done) begin
          sh_q      <= {slave_byte[7:1], rd_q};
          is_addr_q <= 1'b1;
          bit_q     <= 3'd7;
          state_q   <= SQ_SHIFT;
        end
        SQ_SHIFT: if (phy_done) begin
          sh_q <= {sh_q[6:0], phy_rx};
          if (bit_q == 3'd0) state_q <= SQ_ACK;
          else               bit_q   <= bit_q - 3'd1;
        end
        SQ_ACK: if (phy_done) begin
          bit_q <= 3'd7;
          if (rx_phase) begin
            dcnt_q <= dcnt_q + 1'b1;
            state_q <= (dcnt_q == last_q) ? SQ_STOP : SQ_SHIFT;
          end else if (phy_rx) begin
            nack_q  <= 1'b1;
            state_q <= SQ_STOP;
          end else if (is_addr_q) begin
            is_addr_q <= 1'b0;
            state_q   <= SQ_SHIFT;
            if (!rd_q) sh_q <= nxt_byte;
          end else if (dcnt_q == last_q) begin
            state_q <= SQ_STOP;
          end else begin
            dcnt_q  <= nxt_cnt;
            sh_q    <= nxt_byte;
            state_q <= SQ_SHIFT;
          end
        end
        SQ_STOP: if (phy_done) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/short_i2c_regs.sv
module short_i2c_regs
  import short_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_sel,
  output logic [7:0]       rd_data,
  output logic             go,
  output logic             go_read,
  output logic [IDX_W-1:0] go_last,
  output logic [7:0]       slave_byte,
  output data_vec_t        data_vec,
  input  logic             eng_busy,
  input  logic             done,
  input  logic             done_nack,
  input  logic             rx_we,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic [7:0]       rx_byte
);
  logic [7:0] data_q [MAX_BYTES];
  logic [7:0] slave_q, status_q, code_q, rd_q;
  logic       go_q, status_busy, host_ok, legal, start_req;

  assign status_busy = (status_q[7:6] == 2'b01);
  assign host_ok     = wr_en && !status_busy;
  assign legal       = (wr_data[7:3] == 5'b10000);
  assign start_req   = host_ok && (wr_sel == SEL_CTRL) && legal;

  always_ff @(posedge clk) begin
    if (rx_we)
      data_q[rx_idx] <= rx_byte;
    else if (host_ok && !wr_sel[2])
      data_q[wr_sel[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slave_q  <= '0;
      status_q <= '0;
      code_q   <= '0;
      go_q     <= 1'b0;
      rd_q     <= '0;
    end else begin
      go_q <= start_req;
      if (host_ok && wr_sel == SEL_SLAVE) slave_q <= wr_data;
      if (done) begin
        status_q <= done_nack ? (NACK_BASE + {6'd0, code_q[1:0]}) : code_q;
      end else if (start_req) begin
        status_q <= BUSY_BASE | {5'd0, wr_data[2:0]};
        code_q   <= wr_data;
      end
      case (rd_sel)
        3'd0, 3'd1, 3'd2, 3'd3: rd_q <= data_q[rd_sel[IDX_W-1:0]];
        SEL_SLAVE:              rd_q <= slave_q;
        SEL_CTRL:               rd_q <= status_q;
        default:                rd_q <= '0;
      endcase
    end
  end

  for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_vec
    assign data_vec[gi] = data_q[gi];
  end

  assign rd_data    = rd_q;
  assign go         = go_q;
  assign go_read    = code_q[2];
  assign go_last    = code_q[IDX_W-1:0];
  assign slave_byte = slave_q;

  // R4: the engine only runs while status carries the busy form
  assert_busy_status_R4: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> status_busy);

  // R10: host writes during a transfer leave the status untouched
  assert_locked_status_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && status_busy && !done) |=> $stable(status_q));
endmodule

// File: rtl/short_i2c_master.sv
module short_i2c_master
  import short_i2c_pkg::*;
#(
  parameter int unsigned QUARTER_CLKS = 63
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr_en,
  input  logic [2:0] host_wr_sel,
  input  logic [7:0] host_wr_data,
  input  logic [2:0] host_rd_sel,
  output logic [7:0] host_rd_data,
  output logic       scl_out,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic             go, go_read;
  logic [IDX_W-1:0] go_last, rx_idx;
  logic [7:0]       slave_byte, rx_byte;
  data_vec_t        data_vec;
  logic             seq_busy, done, done_nack, rx_we;
  logic             phy_valid, phy_tx, phy_done, phy_rx;
  phy_cmd_e         phy_cmd;

  short_i2c_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_data(host_wr_data),
    .rd_sel(host_rd_sel), .rd_data(host_rd_data),
    .go(go), .go_read(go_read), .go_last(go_last),
    .slave_byte(slave_byte), .data_vec(data_vec),
    .eng_busy(seq_busy), .done(done), .done_nack(done_nack),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );

  short_i2c_seq u_seq (
    .clk(clk), .rst(rst),
    .go(go), .go_read(go_read), .go_last(go_last),
    .slave_byte(slave_byte), .data_vec(data_vec),
    .phy_done(phy_done), .phy_rx(phy_rx),
    .phy_valid(phy_valid), .phy_cmd(phy_cmd), .phy_tx(phy_tx),
    .busy(seq_busy), .done(done), .done_nack(done_nack),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );

  short_i2c_phy #(.QUARTER_CLKS(QUARTER_CLKS)) u_phy (
    .clk(clk), .rst(rst),
    .cmd_valid(phy_valid), .cmd(phy_cmd), .tx_bit(phy_tx),
    .sda_in(sda_in), .cmd_done(phy_done), .rx_bit(phy_rx),
    .scl_out(scl_out), .sda_oe(sda_oe)
  );

  // R12: with the sequencer idle the bus lines rest released
  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
    !seq_busy |-> (scl_out && !sda_oe));
endmodule

// File: tb/test_short_i2c_master.sv
module test_short_i2c_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = 3'd5;
  logic [7:0] rd_data;
  logic       scl_out, sda_oe, sda_in;
  logic       slv_low = 1'b0;

  always #4 clk = ~clk;

  assign sda_in = !sda_oe && !slv_low;

  short_i2c_master #(.QUARTER_CLKS(3)) i_short_i2c_master (
    .clk(clk), .rst(rst),
    .host_wr_en(wr_en), .host_wr_sel(wr_sel), .host_wr_data(wr_data),
    .host_rd_sel(rd_sel), .host_rd_data(rd_data),
    .scl_out(scl_out), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int checks = 0;
  int errors = 0;
  bit bus_quiet = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural slave
  logic [6:0] slv_addr = 7'h50;
  int   nack_at = -1;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit   mack_q[$];
  int   starts = 0, stops = 0;
  bit   pscl = 1'b1, psda = 1'b1;
  bit   active = 0, in_ack = 0, tx_mode = 0, quit = 0, rd_dir = 0;
  int   bitcnt = 0, byteno = 0;
  logic [7:0] sh = '0, tb = '0;

  always @(negedge clk) begin
    bit cur, ok;
    cur = sda_in;
    if (!rst) begin
      if (pscl && scl_out && psda && !cur) begin
        starts++; active = 1; bitcnt = 0; in_ack = 0; tx_mode = 0;
        byteno = 0; quit = 0; sh = '0; slv_low = 1'b0;
      end else if (pscl && scl_out && !psda && cur) begin
        stops++; active = 0; slv_low = 1'b0;
      end else if (active && !pscl && scl_out) begin
        if (!in_ack) begin
          if (!tx_mode) sh = {sh[6:0], cur};
          bitcnt++;
        end else if (tx_mode) begin
          mack_q.push_back(cur);
          if (cur) quit = 1;
        end
      end else if (active && pscl && !scl_out) begin
        if (!in_ack && bitcnt == 8) begin
          in_ack = 1;
          if (tx_mode) slv_low = 1'b0;
          else begin
            if (byteno == 0) begin ok = (sh[7:1] == slv_addr); rd_dir = sh[0]; end
            else begin ok = (byteno != nack_at); rx_q.push_back(sh); end
            slv_low = ok;
            if (!ok) quit = 1;
          end
        end else if (in_ack) begin
          in_ack = 0; bitcnt = 0; slv_low = 1'b0; byteno++;
          if (quit) active = 0;
          else if (rd_dir) begin
            tx_mode = 1;
            tb = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
            slv_low = !tb[7];
          end
        end else if (tx_mode) begin
          slv_low = !tb[7-bitcnt];
        end
      end
    end
    pscl = scl_out;
    psda = cur;
  end

  // per-clock comparison: idle bus whenever the model expects no transfer (R12)
  always @(negedge clk) begin
    if (!rst && bus_quiet) chk(scl_out && !sda_oe, "R12 idle bus", {scl_out, sda_oe}, 2'b10);
  end

  task automatic wreg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  // issue a control code, check busy form, wait for completion
  task automatic run(input logic [7:0] code, output logic [7:0] st);
    logic [7:0] s;
    int n;
    bus_quiet = 1'b0;
    wreg(3'd5, code);
    repeat (3) @(negedge clk);
    rreg(3'd5, s);
    chk(s == (8'h40 | {5'd0, code[2:0]}), "R4 busy status", s, 8'h40 | {5'd0, code[2:0]});
    n = 0;
    do begin rreg(3'd5, s); n++; end while (!s[7] && n < 5000);
    st = s;
    bus_quiet = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st, v;
    int s0, p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rreg(3'd5, v);
    chk(v == 8'h00, "R1 reset status", v, 0);
    chk(scl_out == 1'b1 && sda_oe == 1'b0, "R1 reset bus", {scl_out, sda_oe}, 2'b10);

    // single byte write
    wreg(3'd4, 8'hA0); wreg(3'd3, 8'h3C);
    rx_q.delete(); s0 = starts; p0 = stops;
    run(8'h80, st);
    chk(st == 8'h80, "R5 write status N=1", st, 8'h80);
    chk(rx_q.size() == 1 && rx_q[0] == 8'h3C, "R2 write byte N=1", rx_q.size() ? rx_q[0] : -1, 8'h3C);
    chk(starts == s0 + 1 && stops == p0 + 1, "R9 one start one stop", stops - p0, 1);

    // four byte write, descending register order
    wreg(3'd3, 8'h11); wreg(3'd2, 8'h22); wreg(3'd1, 8'h33); wreg(3'd0, 8'h44);
    rx_q.delete();
    run(8'h83, st);
    chk(st == 8'h83, "R5 write status N=4", st, 8'h83);
    chk(rx_q.size() == 4, "R2 write count N=4", rx_q.size(), 4);
    if (rx_q.size() == 4)
      chk(rx_q[0] == 8'h11 && rx_q[1] == 8'h22 && rx_q[2] == 8'h33 && rx_q[3] == 8'h44,
          "R2 write order N=4", {rx_q[0], rx_q[1], rx_q[2], rx_q[3]}, 32'h11223344);

    // three byte write, register 0 not sent
    wreg(3'd3, 8'hA1); wreg(3'd2, 8'hB2); wreg(3'd1, 8'hC3); wreg(3'd0, 8'hD4);
    rx_q.delete();
    run(8'h82, st);
    chk(st == 8'h82, "R5 write status N=3", st, 8'h82);
    chk(rx_q.size() == 3 && rx_q[2] == 8'hC3, "R2 write N=3", rx_q.size(), 3);

    // single byte read
    tx_q = '{8'h5A}; mack_q.delete();
    run(8'h84, st);
    chk(st == 8'h84, "R6 read status N=1", st, 8'h84);
    rreg(3'd3, v);
    chk(v == 8'h5A, "R3 read byte reg3", v, 8'h5A);
    chk(mack_q.size() == 1 && mack_q[0] == 1'b1, "R8 final nack N=1", mack_q.size(), 1);

    // four byte read
    tx_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF}; mack_q.delete();
    run(8'h87, st);
    chk(st == 8'h87, "R6 read status N=4", st, 8'h87);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'hDE : (i == 1) ? 8'hAD : (i == 2) ? 8'hBE : 8'hEF;
      rreg(3'(3 - i), v);
      chk(v == e, "R3 read order N=4", v, e);
    end
    chk(mack_q.size() == 4 && mack_q[0] == 0 && mack_q[1] == 0 && mack_q[2] == 0 && mack_q[3] == 1,
        "R8 ack pattern N=4", mack_q.size(), 4);

    // two byte read with writes landing mid-transfer
    wreg(3'd1, 8'h61); wreg(3'd0, 8'h60);
    tx_q = '{8'h12, 8'h34}; mack_q.delete(); s0 = starts;
    bus_quiet = 1'b0;
    wreg(3'd5, 8'h85);
    repeat (20) @(negedge clk);
    wreg(3'd1, 8'hEE); wreg(3'd4, 8'h00); wreg(3'd5, 8'h80);
    begin
      int n = 0;
      do begin rreg(3'd5, st); n++; end while (!st[7] && n < 5000);
    end
    bus_quiet = 1'b1;
    chk(st == 8'h85, "R10 ctrl write ignored", st, 8'h85);
    chk(starts == s0 + 1, "R10 no extra start", starts - s0, 1);
    rreg(3'd3, v); chk(v == 8'h12, "R3 read N=2 reg3", v, 8'h12);
    rreg(3'd2, v); chk(v == 8'h34, "R3 read N=2 reg2", v, 8'h34);
    rreg(3'd1, v); chk(v == 8'h61, "R10 data write ignored", v, 8'h61);
    rreg(3'd0, v); chk(v == 8'h60, "R3 reg0 untouched", v, 8'h60);
    rreg(3'd4, v); chk(v == 8'hA0, "R10 address write ignored", v, 8'hA0);

    // address not acknowledged on a write
    wreg(3'd4, 8'h84); rx_q.delete(); p0 = stops;
    run(8'h81, st);
    chk(st == 8'h95, "R7 address nack write", st, 8'h95);
    chk(rx_q.size() == 0 && stops == p0 + 1, "R7 no data after nack", rx_q.size(), 0);

    // second data byte refused
    wreg(3'd4, 8'hA0); wreg(3'd3, 8'h01); wreg(3'd2, 8'h02); wreg(3'd1, 8'h03);
    nack_at = 2; rx_q.delete(); p0 = stops;
    run(8'h82, st);
    nack_at = -1;
    chk(st == 8'h96, "R7 data nack status", st, 8'h96);
    chk(rx_q.size() == 2 && stops == p0 + 1, "R7 remaining bytes skipped", rx_q.size(), 2);

    // address not acknowledged on a read
    wreg(3'd4, 8'h84);
    run(8'h86, st);
    chk(st == 8'h96, "R7 address nack read", st, 8'h96);

    // illegal control codes
    s0 = starts;
    wreg(3'd5, 8'h00); wreg(3'd5, 8'h7F); wreg(3'd5, 8'h88); wreg(3'd5, 8'hFF);
    repeat (40) @(negedge clk);
    rreg(3'd5, v);
    chk(v == 8'h96, "R11 status kept", v, 8'h96);
    chk(starts == s0, "R11 no transfer", starts - s0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule